// File: doc/BRIEF.md
# Parallel DAC Latch Write Sequencer

This block sits between a streaming sample producer and an 8-bit DAC whose parallel input latch is transparent while its active-low chip-enable and chip-select are both low. Samples arrive through a valid/ready handshake. A mode input marks each sample as unsigned or two's complement. Two's-complement samples are turned into offset binary by inverting the top bit, so the most negative value maps to code 0x00 and zero maps to mid-scale 0x80.

For each accepted sample the block does the following in order:

1. It puts the code on the DAC data bus.
2. It lets the bus sit for a setup time.
3. It drives both latch enables low for a strobe time.
4. It releases the enables and keeps the code on the bus for a hold time.
5. It refuses new samples until the converter output has had time to settle.

Every interval is a whole number of clock cycles set by a parameter. Each parameter must be at least 1. The settle default is 100 cycles, which is 1 µs at 100 MHz. All outputs come straight from flip-flops, so the latch enables never glitch.

Top module: `dac_latch_writer`

## Requirements
- R1: While reset is asserted, and after it is released, ce_n and cs_n are 1, dac_d is 0x80 and s_ready is 1, until the first sample is accepted.
- R2: s_ready is 1 only when no write is in progress. A sample is taken at a rising clock edge where s_valid and s_ready are both 1. An idle cycle with s_valid at 0 changes no output.
- R3: With signed_mode at 0, dac_d takes the accepted s_data unchanged.
- R4: With signed_mode at 1, dac_d takes the accepted s_data with bit 7 inverted and bits 6:0 unchanged.
- R5: dac_d changes at the edge that accepts a sample, and at no other edge.
- R6: ce_n and cs_n first go low SETUP_CYCLES edges after the accepting edge. They stay low for exactly STROBE_CYCLES cycles and then return high.
- R7: After the enables return high, s_ready stays 0 for HOLD_CYCLES + SETTLE_CYCLES more cycles. s_ready is therefore 1 again SETUP_CYCLES + STROBE_CYCLES + HOLD_CYCLES + SETTLE_CYCLES edges after the accepting edge.
- R8: Changes on s_valid, s_data and signed_mode while a write is in progress do not affect dac_d, ce_n, cs_n or the timing of s_ready.
- R9: ce_n and cs_n are equal in every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_valid | input | 1 | Sample offered |
| s_ready | output | 1 | Block is idle and will take a sample |
| s_data | input | 8 | Sample value |
| signed_mode | input | 1 | 1: sample is two's complement; 0: unsigned |
| dac_d | output | 8 | Registered DAC data bus |
| ce_n | output | 1 | Active-low latch chip-enable |
| cs_n | output | 1 | Active-low latch chip-select |

## Verification
A wrong phase or miscounted timer shows at the ports within one write. Either the enables fall too early or last the wrong number of cycles, or s_ready comes back on the wrong edge. The bench compares each of these against arithmetic expectations on every cycle of every write. A wrong code path, such as a missing or misplaced bit flip, shows on dac_d one cycle after acceptance. An unwanted update shows on dac_d at the first edge where a busy-time input is taken. The sweep covers all 256 sample values in both modes, back to back. It also feeds changing inputs during busy windows and applies a reset partway through a strobe.

// File: rtl/dac_wr_pkg.sv
package dac_wr_pkg;

    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_SETUP  = 3'd1,
        PH_STROBE = 3'd2,
        PH_HOLD   = 3'd3,
        PH_SETTLE = 3'd4
    } wr_phase_e;

    function automatic int max_of4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/dac_code_map.sv
module dac_code_map #(
    parameter int W = 8
) (
    input  logic [W-1:0] raw,
    input  logic         twos_comp,
    output logic [W-1:0] code
);
    // Offset binary: flipping the sign bit shifts the range up by half scale.
    assign code = {raw[W-1] ^ twos_comp, raw[W-2:0]};
endmodule

// File: rtl/dac_phase_timer.sv
module dac_phase_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          zero
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero = (cnt_q == '0);

    // An expired timer stays expired until the sequencer reloads it.
    assert_timer_parks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (zero && !load) |=> zero);
endmodule

// File: rtl/dac_latch_writer.sv
module dac_latch_writer #(
    parameter int DATA_W        = 8,
    parameter int SETUP_CYCLES  = 2,
    parameter int STROBE_CYCLES = 3,
    parameter int HOLD_CYCLES   = 2,
    parameter int SETTLE_CYCLES = 100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s_valid,
    output logic              s_ready,
    input  logic [DATA_W-1:0] s_data,
    input  logic              signed_mode,
    output logic [DATA_W-1:0] dac_d,
    output logic              ce_n,
    output logic              cs_n
);
    import dac_wr_pkg::*;

    localparam int LONGEST = max_of4(SETUP_CYCLES, STROBE_CYCLES, HOLD_CYCLES, SETTLE_CYCLES);
    localparam int CNT_W   = $clog2(LONGEST) + 1;
    localparam logic [CNT_W-1:0] SETUP_LD  = CNT_W'(SETUP_CYCLES - 1);
    localparam logic [CNT_W-1:0] STROBE_LD = CNT_W'(STROBE_CYCLES - 1);
    localparam logic [CNT_W-1:0] HOLD_LD   = CNT_W'(HOLD_CYCLES - 1);
    localparam logic [CNT_W-1:0] SETTLE_LD = CNT_W'(SETTLE_CYCLES - 1);
    localparam logic [DATA_W-1:0] MID_SCALE = {1'b1, {(DATA_W-1){1'b0}}};

    typedef struct packed {
        wr_phase_e          phase;
        logic [DATA_W-1:0]  dac;
        logic               ce_n;
        logic               cs_n;
    } wr_regs_t;

    localparam wr_regs_t RESET_VAL = '{phase: PH_IDLE, dac: MID_SCALE, ce_n: 1'b1, cs_n: 1'b1};

    wr_regs_t          regs_d, regs_q;
    logic [DATA_W-1:0] enc_code;
    logic              tmr_load;
    logic [CNT_W-1:0]  tmr_val;
    logic              tmr_zero;

    dac_code_map #(.W(DATA_W)) u_code_map (
        .raw       (s_data),
        .twos_comp (signed_mode),
        .code      (enc_code)
    );

    dac_phase_timer #(.CW(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    always_comb begin
        regs_d   = regs_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (regs_q.phase)
            PH_IDLE: begin
                if (s_valid) begin
                    regs_d.phase = PH_SETUP;
                    regs_d.dac   = enc_code;
                    tmr_load     = 1'b1;
                    tmr_val      = SETUP_LD;
                end
            end
            PH_SETUP: begin
                if (tmr_zero) begin
                    regs_d.phase = PH_STROBE;
                    regs_d.ce_n  = 1'b0;
                    regs_d.cs_n  = 1'b0;
                    tmr_load     = 1'b1;
                    tmr_val      = STROBE_LD;
                end
            end
            PH_STROBE: begin
                if (tmr_zero) begin
                    regs_d.phase = PH_HOLD;
                    regs_d.ce_n  = 1'b1;
                    regs_d.cs_n  = 1'b1;
                    tmr_load     = 1'b1;
                    tmr_val      = HOLD_LD;
                end
            end
            PH_HOLD: begin
                if (tmr_zero) begin
                    regs_d.phase = PH_SETTLE;
                    tmr_load     = 1'b1;
                    tmr_val      = SETTLE_LD;
                end
            end
            PH_SETTLE: begin
                if (tmr_zero) regs_d.phase = PH_IDLE;
            end
            default: regs_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= RESET_VAL;
        else        regs_q <= regs_d;
    end

    assign s_ready = (regs_q.phase == PH_IDLE);
    assign dac_d   = regs_q.dac;
    assign ce_n    = regs_q.ce_n;
    assign cs_n    = regs_q.cs_n;

    assert_enables_paired_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n == cs_n);

    assert_no_ready_in_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !ce_n |-> !s_ready);

    assert_bus_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(s_valid && s_ready) |=> $stable(dac_d));

    assert_bus_settled_before_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ce_n) |-> ($stable(dac_d) && !$past(s_ready)));

    assert_lockout_after_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ce_n) |-> !s_ready);
endmodule

// File: tb/dac_latch_writer_bench.sv
module dac_latch_writer_bench;
    localparam int SU = 2;
    localparam int ST = 3;
    localparam int HO = 1;
    localparam int SE = 4;
    localparam int TOTAL = SU + ST + HO + SE;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       s_valid = 1'b0;
    logic       s_ready;
    logic [7:0] s_data = 8'h00;
    logic       signed_mode = 1'b0;
    logic [7:0] dac_d;
    logic       ce_n, cs_n;

    int  checks = 0;
    int  fails  = 0;
    bit  finished = 1'b0;

    always #4 clk = ~clk;

    dac_latch_writer #(
        .DATA_W(8), .SETUP_CYCLES(SU), .STROBE_CYCLES(ST),
        .HOLD_CYCLES(HO), .SETTLE_CYCLES(SE)
    ) u_dac_latch_writer (
        .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
        .s_data(s_data), .signed_mode(signed_mode), .dac_d(dac_d),
        .ce_n(ce_n), .cs_n(cs_n)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic check_idle_outputs(input string req, input logic [7:0] exp_d);
        chk(ce_n == 1'b1, req, "ce_n", ce_n, 1);
        chk(cs_n == 1'b1, req, "cs_n", cs_n, 1);
        chk(s_ready == 1'b1, req, "s_ready", s_ready, 1);
        chk(dac_d == exp_d, req, "dac_d", dac_d, exp_d);
    endtask

    // Called at a falling edge with the block idle; returns at the falling edge
    // where s_ready is back, so consecutive calls run back to back.
    task automatic write_one(input logic [7:0] d, input logic m, input bit noise);
        logic [7:0] exp;
        bit         low_exp;
        s_data = d; signed_mode = m; s_valid = 1'b1;
        exp = m ? (d ^ 8'h80) : d;
        for (int k = 1; k <= TOTAL + 1; k++) begin
            @(negedge clk);
            if (k == 1) chk(dac_d == exp, m ? "R4" : "R3", "dac_d code", dac_d, exp);
            else        chk(dac_d == exp, noise ? "R8" : "R5", "dac_d held", dac_d, exp);
            low_exp = (k >= SU + 1) && (k <= SU + ST);
            chk(ce_n == !low_exp, noise ? "R8" : "R6", "ce_n phase", ce_n, !low_exp);
            chk(cs_n == ce_n, "R9", "cs_n vs ce_n", cs_n, ce_n);
            chk(s_ready == (k == TOTAL + 1), noise ? "R8" : "R7", "s_ready timing", s_ready, (k == TOTAL + 1));
            if (k == 1) begin
                if (noise) begin
                    s_data = d ^ 8'h5A; signed_mode = ~m;
                end else begin
                    s_valid = 1'b0;
                end
            end
            if (k == TOTAL) s_valid = 1'b0;
        end
    endtask

    initial begin
        @(negedge clk);
        check_idle_outputs("R1", 8'h80);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_idle_outputs("R1", 8'h80);

        // R2: idle with no valid changes nothing.
        s_data = 8'h3C; signed_mode = 1'b1;
        repeat (3) @(negedge clk);
        check_idle_outputs("R2", 8'h80);

        for (int m = 0; m < 2; m++)
            for (int v = 0; v < 256; v++)
                write_one(8'(v), m[0], (v % 3) == 0);

        // R2: idle after a write keeps the last code.
        repeat (2) @(negedge clk);
        check_idle_outputs("R2", 8'hFF ^ 8'h80);

        // R1: reset in the middle of a strobe.
        s_data = 8'h11; signed_mode = 1'b0; s_valid = 1'b1;
        @(negedge clk);
        s_valid = 1'b0;
        repeat (SU + 1) @(negedge clk);
        chk(ce_n == 1'b0, "R6", "ce_n before mid reset", ce_n, 0);
        #1 rst_n = 1'b0;
        #1 check_idle_outputs("R1", 8'h80);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_idle_outputs("R1", 8'h80);

        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule